// File: doc/BRIEF.md
# Single-Slot Mailbox with External Writer

This block holds at most one data word and passes it between producers and consumers. Two producers can deposit a word. One is internal, with a request and a grant. The other is external, with data, a write enable, a put strobe and a put acknowledge. An internal consumer takes the word out with a get. The get stalls for as long as the slot is empty. The slot is never overwritten: a producer whose put arrives while the slot is occupied keeps its request raised until a get frees the slot.

Alongside the slot there is a broadcast path. A notify, raised either by the internal side or by the external writer, hands its value to every consumer that is currently waiting. Each waiting consumer sees a wake-up strobe and the value in the same cycle. A notify neither reads nor writes the slot. When no consumer is waiting, the notify is lost. All acknowledges and grants are combinational and valid in the cycle of the request. The slot and its occupancy flag change at the following clock edge.

Top module: `mbox_single_slot`

## Requirements
- R1: After reset the slot is empty. A get is not acknowledged until a put has been accepted.
- R2: When getAck is high, getData carries the word from the most recently accepted put. When getAck is low, getData is zero.
- R3: An external put is a cycle with extWen and extPut both high. It is acknowledged by extPutAck in that same cycle only if the slot is empty. While the slot is full, extPutAck stays low and the word is not stored.
- R4: A get (getReq high) is acknowledged by getAck in the same cycle only if the slot is full, and the slot is empty from the next cycle on. If a get and a put occur together while the slot is full, the get is served and the put waits.
- R5: During a notify, waitAck equals waitReq (bit i for waiter i) and waitData carries the notify value.
- R6: A notify never changes the slot contents or its occupancy, whether or not any waiter is present. A notify with no waiter is dropped.
- R7: When an internal put and an external put are both requested in the same cycle and the slot is empty, only the external one is accepted. The internal request is granted (inPutGnt) in a later cycle in which the slot is empty and there is no external put.
- R8: An external notify is a cycle with extWen and extNotify both high. If it coincides with an internal notify (inNotifyReq), waitData carries extData.
- R9: In a cycle with no notify, waitAck and waitData are zero.
- R10: While extWen is low, extPut and extNotify have no effect: there is no acknowledge, no store and no wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extData | input | W | External writer data |
| extWen | input | 1 | External write enable, qualifies extPut and extNotify |
| extPut | input | 1 | External put strobe |
| extNotify | input | 1 | External notify strobe |
| extPutAck | output | 1 | External put accepted this cycle |
| inPutReq | input | 1 | Internal put request |
| inPutData | input | W | Internal put data |
| inPutGnt | output | 1 | Internal put accepted this cycle |
| getReq | input | 1 | Internal get request |
| getAck | output | 1 | Get served this cycle |
| getData | output | W | Word returned by the get |
| inNotifyReq | input | 1 | Internal notify request |
| inNotifyData | input | W | Internal notify value |
| waitReq | input | N | Per-waiter waiting flags |
| waitAck | output | N | Per-waiter wake-up strobes |
| waitData | output | W | Value delivered to woken waiters |

## Verification
Directed phases exercise the following cases:
- a fill followed by a drain;
- a put against a full slot, which must stall;
- a get against an empty slot;
- simultaneous internal and external puts;
- a get together with a put on a full slot;
- notifies with no waiter, with some waiters and with all waiters;
- coinciding external and internal notifies;
- put and notify strobes with the write enable low.

Each of these separates one arbitration or ordering choice from its wrong alternative. A long pseudo-random phase then mixes every input. A queue-based model checks all outputs on every cycle, so a lost word, a double store or a notify that touches the slot shows up as a data or acknowledge mismatch.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef struct packed {
    logic takeExt;    // store external word at edge
    logic takeInt;    // store internal word at edge
    logic drain;      // slot consumed this cycle
    logic notifyExt;  // broadcast source is external
    logic notifyOn;   // broadcast active this cycle
  } mboxStrobes_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         extPutReq,
  input  logic         inPutReq,
  input  logic         getReq,
  input  logic         extNotifyReq,
  input  logic         inNotifyReq,
  output mboxStrobes_t strobes
);
  logic full;

  always_comb begin
    strobes.takeExt   = extPutReq & ~full;
    strobes.takeInt   = inPutReq & ~full & ~extPutReq;
    strobes.drain     = getReq & full;
    strobes.notifyExt = extNotifyReq;
    strobes.notifyOn  = extNotifyReq | inNotifyReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) full <= 1'b0;
    else       full <= (full & ~strobes.drain) | strobes.takeExt | strobes.takeInt;
  end
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int W = 16,
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  mboxStrobes_t strobes,
  input  logic [W-1:0] extData,
  input  logic [W-1:0] inPutData,
  input  logic [W-1:0] inNotifyData,
  input  logic [N-1:0] waitReq,
  output logic [W-1:0] getData,
  output logic [W-1:0] waitData,
  output logic [N-1:0] waitAck
);
  logic [W-1:0] slot;

  always_ff @(posedge clk) begin
    if (!rstN)                slot <= '0;
    else if (strobes.takeExt) slot <= extData;
    else if (strobes.takeInt) slot <= inPutData;
  end

  assign getData = strobes.drain ? slot : '0;

  always_comb begin
    if (!strobes.notifyOn)      waitData = '0;
    else if (strobes.notifyExt) waitData = extData;
    else                        waitData = inNotifyData;
  end

  for (genvar i = 0; i < N; i++) begin : gWaiter
    assign waitAck[i] = strobes.notifyOn & waitReq[i];
  end
endmodule

// File: rtl/mbox_single_slot.sv
module mbox_single_slot
  import mbox_pkg::*;
#(
  parameter int W = 16,
  parameter int NUM_WAITERS = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [W-1:0]           extData,
  input  logic                   extWen,
  input  logic                   extPut,
  input  logic                   extNotify,
  output logic                   extPutAck,
  input  logic                   inPutReq,
  input  logic [W-1:0]           inPutData,
  output logic                   inPutGnt,
  input  logic                   getReq,
  output logic                   getAck,
  output logic [W-1:0]           getData,
  input  logic                   inNotifyReq,
  input  logic [W-1:0]           inNotifyData,
  input  logic [NUM_WAITERS-1:0] waitReq,
  output logic [NUM_WAITERS-1:0] waitAck,
  output logic [W-1:0]           waitData
);
  mboxStrobes_t strobes;

  mbox_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .extPutReq(extWen & extPut), .inPutReq(inPutReq), .getReq(getReq),
    .extNotifyReq(extWen & extNotify), .inNotifyReq(inNotifyReq),
    .strobes(strobes)
  );

  mbox_datapath #(.W(W), .N(NUM_WAITERS)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .extData(extData), .inPutData(inPutData), .inNotifyData(inNotifyData),
    .waitReq(waitReq), .getData(getData), .waitData(waitData), .waitAck(waitAck)
  );

  assign extPutAck = strobes.takeExt;
  assign inPutGnt  = strobes.takeInt;
  assign getAck    = strobes.drain;
endmodule

// File: rtl/mbox_single_slot_chk.sv
module mbox_single_slot_chk #(
  parameter int W = 16,
  parameter int NUM_WAITERS = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [W-1:0]           extData,
  input logic                   extWen,
  input logic                   extPut,
  input logic                   extNotify,
  input logic                   extPutAck,
  input logic                   inPutReq,
  input logic [W-1:0]           inPutData,
  input logic                   inPutGnt,
  input logic                   getReq,
  input logic                   getAck,
  input logic [W-1:0]           getData,
  input logic                   inNotifyReq,
  input logic [W-1:0]           inNotifyData,
  input logic [NUM_WAITERS-1:0] waitReq,
  input logic [NUM_WAITERS-1:0] waitAck,
  input logic [W-1:0]           waitData
);
  AST_EXT_WORD_RETURNED: assert property (@(posedge clk) disable iff (!rstN)
    extPutAck |=> (getAck |-> getData == $past(extData))); // R2
  AST_INT_WORD_RETURNED: assert property (@(posedge clk) disable iff (!rstN)
    inPutGnt |=> (getAck |-> getData == $past(inPutData))); // R2
  AST_NO_DOUBLE_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (extPutAck || inPutGnt) |=> !(extPutAck || inPutGnt)); // R3
  AST_NO_DOUBLE_GET: assert property (@(posedge clk) disable iff (!rstN)
    getAck |=> !getAck); // R4
  AST_SINGLE_PUT_WINNER: assert property (@(posedge clk) disable iff (!rstN)
    !(extPutAck && inPutGnt)); // R7
  AST_EXT_PUT_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    (extWen && extPut) |-> !inPutGnt); // R7
  AST_WAKE_ALL_WAITERS: assert property (@(posedge clk) disable iff (!rstN)
    (extWen && extNotify) |-> (waitAck == waitReq && waitData == extData)); // R8
  AST_QUIET_WAITERS: assert property (@(posedge clk) disable iff (!rstN)
    !(extWen && extNotify) && !inNotifyReq |-> (waitAck == '0 && waitData == '0)); // R9
  AST_WEN_GATES_PUT: assert property (@(posedge clk) disable iff (!rstN)
    !extWen |-> !extPutAck); // R10
endmodule

bind mbox_single_slot mbox_single_slot_chk #(.W(W), .NUM_WAITERS(NUM_WAITERS)) uChk (.*);

// File: tb/sim_mbox_single_slot.sv
module sim_mbox_single_slot;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int N = 3;

  logic clk = 0, rstN = 0;
  logic [W-1:0] extData = '0, inPutData = '0, inNotifyData = '0;
  logic extWen = 0, extPut = 0, extNotify = 0, inPutReq = 0, getReq = 0, inNotifyReq = 0;
  logic [N-1:0] waitReq = '0;
  logic extPutAck, inPutGnt, getAck;
  logic [W-1:0] getData, waitData;
  logic [N-1:0] waitAck;

  int vectors = 0, miscompares = 0;
  string phase = "R1";
  logic [W-1:0] model[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_single_slot #(.W(W), .NUM_WAITERS(N)) u0 (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s (%s) actual=%0h expected=%0h t=%0t", tag, phase, act, exp, $time);
    end
  endtask

  // Reference model compared on every falling edge
  always @(negedge clk) if (rstN) begin
    bit eput, enot, xAck, iGnt, gAck;
    logic [W-1:0] gData, wData;
    logic [N-1:0] wAck;
    eput = extWen && extPut;
    enot = extWen && extNotify;
    xAck = eput && model.size() == 0;
    iGnt = inPutReq && model.size() == 0 && !eput;
    gAck = getReq && model.size() == 1;
    gData = gAck ? model[0] : '0;
    wAck = (enot || inNotifyReq) ? waitReq : '0;
    wData = enot ? extData : (inNotifyReq ? inNotifyData : '0);
    check(extPutAck == xAck, "R3 extPutAck", extPutAck, xAck);
    check(inPutGnt == iGnt, "R7 inPutGnt", inPutGnt, iGnt);
    check(getAck == gAck, "R4 getAck", getAck, gAck);
    check(getData == gData, "R2 getData", getData, gData);
    check(waitAck == wAck, "R5 waitAck", waitAck, wAck);
    check(waitData == wData, "R9 waitData", waitData, wData);
    if (gAck) void'(model.pop_front());
    if (xAck) model.push_back(extData);
    if (iGnt) model.push_back(inPutData);
  end

  task automatic idle();
    extWen = 0; extPut = 0; extNotify = 0; inPutReq = 0; getReq = 0;
    inNotifyReq = 0; waitReq = '0;
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] lfsr = 32'h1ACE_B00C;
    step(3);
    rstN = 1;
    // R1: get after reset is not served
    phase = "R1"; getReq = 1; step(); idle();
    // R3/R2: external fill, stall while full, drain
    phase = "R3"; extWen = 1; extPut = 1; extData = 16'hA5A5; step();
    extData = 16'h1234; step(2);           // stalled, not stored
    idle(); phase = "R2"; getReq = 1; step(); getReq = 0;
    extWen = 1; extPut = 1; step(); idle();  // 1234 lands now
    getReq = 1; step(); idle();
    // R4: get on empty, then get+put on full
    phase = "R4"; getReq = 1; step();
    inPutReq = 1; inPutData = 16'h0F0F; getReq = 0; step();
    inPutData = 16'h7777; getReq = 1; step(); // get served, put waits
    getReq = 0; step(); idle(); getReq = 1; step(); idle();
    // R7: collision, ext wins, internal retries
    phase = "R7"; extWen = 1; extPut = 1; extData = 16'hBEEF;
    inPutReq = 1; inPutData = 16'hCAFE; step();
    extWen = 0; extPut = 0; step(); getReq = 1; step();
    getReq = 0; step(); getReq = 1; inPutReq = 0; step(); idle();
    // R6: notify with no waiter, and with waiters, slot untouched
    phase = "R6"; inNotifyReq = 1; inNotifyData = 16'h5555; step();
    getReq = 1; inNotifyReq = 0; step(); idle();
    extWen = 1; extPut = 1; extData = 16'h4242; step(); idle();
    phase = "R5"; waitReq = 3'b101; inNotifyReq = 1; inNotifyData = 16'h9999; step();
    waitReq = 3'b111; step(); idle();
    phase = "R6"; getReq = 1; step(); idle();
    // R8: both notifies in one cycle
    phase = "R8"; waitReq = 3'b011; extWen = 1; extNotify = 1; extData = 16'hE0E0;
    inNotifyReq = 1; inNotifyData = 16'h0E0E; step(); idle();
    // R10: enable low gates put and notify
    phase = "R10"; extPut = 1; extNotify = 1; waitReq = 3'b111; extData = 16'hDEAD; step();
    extPut = 0; extNotify = 0; waitReq = 0; getReq = 1; step(); idle();
    // R9 and mix: pseudo-random traffic
    phase = "R9";
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      extWen = lfsr[0] | lfsr[5]; extPut = lfsr[1]; extNotify = lfsr[2] & lfsr[9];
      inPutReq = lfsr[3]; getReq = lfsr[4]; inNotifyReq = lfsr[6] & lfsr[11];
      waitReq = lfsr[14:12]; extData = lfsr[31:16]; inPutData = lfsr[23:8];
      inNotifyData = ~lfsr[27:12];
      step();
    end
    idle(); step(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule